// File: doc/BRIEF.md
# Pin Override Controller with Power-Button Auto-Block

This block sits on the path between seven functional signals and the pins that carry them out of the chip: battery disable, controller reset, power button, three keyboard lines and a wake line. In normal operation each pin simply carries its functional value, optionally inverted. Software may force any pin to a fixed level, but only to a level that a separately held permission mask allows. A hardware auto-block can also take over selected keyboard lines. Once the power button has been pressed and held through a programmable debounce time, those lines are driven to programmed levels.

The permission mask, the polarity settings and the auto-block settings sit behind a write-enable bit. Once that bit is cleared, it stays cleared until the next reset. The override enable and override value registers stay writable at all times. After reset the controller reset pin is held low by the default permission and enable values, and it is released only when software clears its override enable. Register writes arrive as plain write strobes with data, one pair per register; address decoding belongs to the surrounding bus logic.

Top module: `pin_override_ctrl`

## Requirements
- R1: After reset, pin 1 (controller reset) is driven low whatever its functional input. Every other pin follows its functional input, and `cfg_wen_o` is 1.
- R2: With no override and no auto-block, each pin equals its functional input XOR polarity bit i (`pol_wdata_i[6:0]`). Pin index order is 0 battery disable, 1 controller reset, 2 power button, 3/4/5 key0/key1/key2, 6 wake.
- R3: A pin whose override enable bit is 1 is driven to its override value bit when that value is permitted. Forcing 0 is permitted by allow bit i. Forcing 1 is permitted by allow bit 7+i.
- R4: An override that requests a value that is not permitted has no effect, and the pin keeps its normal behaviour.
- R5: Output inversion is applied after override and auto-block, so a forced value also passes through the pin's polarity bit.
- R6: A pulse on `wen_clr_i` clears `cfg_wen_o` until the next reset. After that, writes to the allow, polarity and auto-block registers are ignored, while override enable and value writes still take effect. A locked write issued in the same cycle as the lock pulse still lands.
- R7: With auto-block enabled, a high-to-low change of the power-button level that stays low for the programmed number of ticks drives each selected key (select bits 0..2 = key0..key2) to its programmed value. Unselected keys are untouched.
- R8: If the power button returns high before the debounce time ends, no blocking occurs. If it returns high while blocking, the keys are released one cycle later.
- R9: An override that is enabled and permitted takes priority over auto-block on the same pin.
- R10: Polarity bit 7 inverts the power-button level before detection, so that a raw rising edge starts auto-block.
- R11: The debounce count advances only on cycles where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Debounce time base enable (one per 5 us) |
| func_i | input | 7 | Functional value for each pin |
| pins_o | output | 7 | Pin outputs after override, auto-block and inversion |
| wen_clr_i | input | 1 | Pulse to lock configuration |
| cfg_wen_o | output | 1 | 1 while configuration is writable |
| allow_we_i | input | 1 | Allow mask write strobe (locked) |
| allow_wdata_i | input | 14 | [6:0] permit forcing 0, [13:7] permit forcing 1 |
| pol_we_i | input | 1 | Polarity write strobe (locked) |
| pol_wdata_i | input | 8 | [6:0] output inversion, [7] power-button input inversion |
| abt_we_i | input | 1 | Auto-block timer write strobe (locked) |
| abt_wdata_i | input | 17 | [15:0] debounce ticks, [16] enable |
| abo_we_i | input | 1 | Auto-block output write strobe (locked) |
| abo_sel_i | input | 3 | Keys to block, bit k = key k |
| abo_val_i | input | 3 | Value for each blocked key |
| ovr_en_we_i | input | 1 | Override enable write strobe |
| ovr_en_wdata_i | input | 7 | Override enable per pin |
| ovr_val_we_i | input | 1 | Override value write strobe |
| ovr_val_wdata_i | input | 7 | Override value per pin |

## Verification
Two functions can meet in one cycle on the same key pin: a permitted software override and an active auto-block. The bench holds the power button low until blocking is established, then enables an override on key0 with the opposite value and judges that the override value appears at the pin. A second meeting point is a lock pulse issued in the same cycle as a polarity write. The bench drives both strobes together and expects the write to land while `cfg_wen_o` drops, and it expects later writes to be ignored.

// File: rtl/pin_override_ctrl.sv
module pin_override_ctrl #(
  parameter int NPINS    = 7,
  parameter int DBW      = 16,
  parameter int NKEYS    = 3,
  parameter int KEY_LO   = 3,
  parameter int PWRB_IDX = 2,
  parameter int RST_IDX  = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [NPINS-1:0]     func_i,
  output logic [NPINS-1:0]     pins_o,
  input  logic                 wen_clr_i,
  output logic                 cfg_wen_o,
  input  logic                 allow_we_i,
  input  logic [2*NPINS-1:0]   allow_wdata_i,
  input  logic                 pol_we_i,
  input  logic [NPINS:0]       pol_wdata_i,
  input  logic                 abt_we_i,
  input  logic [DBW:0]         abt_wdata_i,
  input  logic                 abo_we_i,
  input  logic [NKEYS-1:0]     abo_sel_i,
  input  logic [NKEYS-1:0]     abo_val_i,
  input  logic                 ovr_en_we_i,
  input  logic [NPINS-1:0]     ovr_en_wdata_i,
  input  logic                 ovr_val_we_i,
  input  logic [NPINS-1:0]     ovr_val_wdata_i
);

  localparam logic [2*NPINS-1:0] ALLOW_RST = (2*NPINS)'(1) << RST_IDX;
  localparam logic [NPINS-1:0]   OVR_RST   = NPINS'(1) << RST_IDX;

  typedef enum logic [1:0] {AB_IDLE, AB_DEB, AB_BLK} ab_st_e;

  logic               wen_q;
  logic [2*NPINS-1:0] allow_q;
  logic [NPINS:0]     pol_q;
  logic [DBW-1:0]     tmr_q;
  logic               ab_en_q;
  logic [NKEYS-1:0]   sel_q, val_q;
  logic [NPINS-1:0]   ovr_en_q, ovr_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q     <= 1'b1;
      allow_q   <= ALLOW_RST;
      pol_q     <= '0;
      tmr_q     <= '0;
      ab_en_q   <= 1'b0;
      sel_q     <= '0;
      val_q     <= '0;
      ovr_en_q  <= OVR_RST;
      ovr_val_q <= '0;
    end else begin
      if (wen_clr_i) wen_q <= 1'b0;
      if (wen_q && allow_we_i) allow_q <= allow_wdata_i;
      if (wen_q && pol_we_i) pol_q <= pol_wdata_i;
      if (wen_q && abt_we_i) begin
        tmr_q   <= abt_wdata_i[DBW-1:0];
        ab_en_q <= abt_wdata_i[DBW];
      end
      if (wen_q && abo_we_i) begin
        sel_q <= abo_sel_i;
        val_q <= abo_val_i;
      end
      if (ovr_en_we_i)  ovr_en_q  <= ovr_en_wdata_i;
      if (ovr_val_we_i) ovr_val_q <= ovr_val_wdata_i;
    end
  end

  assign cfg_wen_o = wen_q;

  logic pwrb_now, pwrb_q, pwrb_fall;
  assign pwrb_now  = func_i[PWRB_IDX] ^ pol_q[NPINS];
  assign pwrb_fall = pwrb_q & ~pwrb_now;

  ab_st_e         st_q;
  logic [DBW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwrb_q <= 1'b0;
      st_q   <= AB_IDLE;
      cnt_q  <= '0;
    end else begin
      pwrb_q <= pwrb_now;
      case (st_q)
        AB_IDLE: if (ab_en_q && pwrb_fall) begin
          st_q  <= AB_DEB;
          cnt_q <= '0;
        end
        AB_DEB: begin
          if (!ab_en_q || pwrb_now) st_q <= AB_IDLE;
          else if (cnt_q >= tmr_q)  st_q <= AB_BLK;
          else if (tick_i)          cnt_q <= cnt_q + 1'b1;
        end
        AB_BLK: if (!ab_en_q || pwrb_now) st_q <= AB_IDLE;
        default: st_q <= AB_IDLE;
      endcase
    end
  end

  logic blocking;
  assign blocking = (st_q == AB_BLK);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic forced, normal;
    assign forced = ovr_en_q[i] &
                    (ovr_val_q[i] ? allow_q[NPINS+i] : allow_q[i]);
    if (i >= KEY_LO && i < KEY_LO + NKEYS) begin : g_key
      assign normal = (blocking && sel_q[i-KEY_LO]) ? val_q[i-KEY_LO] : func_i[i];
    end else begin : g_plain
      assign normal = func_i[i];
    end
    assign pins_o[i] = (forced ? ovr_val_q[i] : normal) ^ pol_q[i];
  end

  // R6
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |=> !wen_q);

  // R6
  locked_cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |=> ($stable(allow_q) && $stable(pol_q) && $stable(tmr_q) && $stable(sel_q)));

  // R8
  release_unblocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocking && pwrb_now) |=> !blocking);

  // R7
  block_after_debounce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blocking) |-> $past(st_q == AB_DEB));

  // R7
  disabled_no_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ab_en_q |=> !blocking);

endmodule

// File: tb/pin_override_ctrl_tb.sv
module pin_override_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic [6:0] func = '0;
  logic [6:0] pins;
  logic wen_clr = 0, cfg_wen;
  logic allow_we = 0; logic [13:0] allow_wd = '0;
  logic pol_we = 0;   logic [7:0]  pol_wd = '0;
  logic abt_we = 0;   logic [16:0] abt_wd = '0;
  logic abo_we = 0;   logic [2:0]  abo_sel = '0, abo_val = '0;
  logic oen_we = 0;   logic [6:0]  oen_wd = '0;
  logic ova_we = 0;   logic [6:0]  ova_wd = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pin_override_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .func_i(func), .pins_o(pins),
    .wen_clr_i(wen_clr), .cfg_wen_o(cfg_wen),
    .allow_we_i(allow_we), .allow_wdata_i(allow_wd),
    .pol_we_i(pol_we), .pol_wdata_i(pol_wd),
    .abt_we_i(abt_we), .abt_wdata_i(abt_wd),
    .abo_we_i(abo_we), .abo_sel_i(abo_sel), .abo_val_i(abo_val),
    .ovr_en_we_i(oen_we), .ovr_en_wdata_i(oen_wd),
    .ovr_val_we_i(ova_we), .ovr_val_wdata_i(ova_wd));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_allow(logic [13:0] d);
    allow_wd = d; allow_we = 1; cyc(1); allow_we = 0;
  endtask
  task automatic wr_pol(logic [7:0] d);
    pol_wd = d; pol_we = 1; cyc(1); pol_we = 0;
  endtask
  task automatic wr_oen(logic [6:0] d);
    oen_wd = d; oen_we = 1; cyc(1); oen_we = 0;
  endtask
  task automatic wr_ova(logic [6:0] d);
    ova_wd = d; ova_we = 1; cyc(1); ova_we = 0;
  endtask
  task automatic wr_ab(logic en, logic [15:0] t, logic [2:0] s, logic [2:0] v);
    abt_wd = {en, t}; abt_we = 1; abo_sel = s; abo_val = v; abo_we = 1;
    cyc(1); abt_we = 0; abo_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
  endtask

  task automatic t_reset();
    func = 7'h7F; cyc(1);
    check("R1 reset pins high in", {1'b0, pins}, 8'h7D);
    check("R1 reset wen", {7'b0, cfg_wen}, 8'h01);
    func = 7'h00; cyc(1);
    check("R1 reset pins low in", {1'b0, pins}, 8'h00);
  endtask

  task automatic t_pass();
    wr_oen(7'h00);
    func = 7'h2A; cyc(1);
    check("R2 plain pass", {1'b0, pins}, 8'h2A);
    wr_pol(8'h05);
    check("R2 inverted pass", {1'b0, pins}, 8'h2F);
    func = 7'h55; cyc(1);
    check("R2 inverted pass 2", {1'b0, pins}, 8'h50);
    wr_pol(8'h00);
  endtask

  task automatic t_override();
    wr_allow(14'h3FFF); wr_ova(7'h55); wr_oen(7'h7F);
    func = 7'h2A; cyc(1);
    check("R3 all permitted", {1'b0, pins}, 8'h55);
    wr_allow(14'h007F);
    func = 7'h7F; cyc(1);
    check("R4 only zero permitted, in high", {1'b0, pins}, 8'h55);
    func = 7'h00; cyc(1);
    check("R4 only zero permitted, in low", {1'b0, pins}, 8'h00);
    wr_allow(14'h3F80);
    check("R4 only one permitted, in low", {1'b0, pins}, 8'h55);
    func = 7'h7F; cyc(1);
    check("R3 only one permitted, in high", {1'b0, pins}, 8'h7F);
    wr_allow(14'h3FFF); wr_pol(8'h7F);
    check("R5 forced then inverted", {1'b0, pins}, 8'h2A);
    wr_pol(8'h00); wr_oen(7'h00);
  endtask

  task automatic t_autoblock();
    wr_ab(1'b1, 16'd20, 3'b101, 3'b100);
    func = 7'h5F; cyc(2);
    func = 7'h5B; cyc(10);
    check("R7 before debounce", {1'b0, pins}, 8'h5B);
    cyc(15);
    check("R7 blocked keys", {1'b0, pins}, 8'h73);
    wr_ova(7'h08); wr_oen(7'h08);
    check("R9 override beats block", {1'b0, pins}, 8'h7B);
    wr_oen(7'h00);
    check("R9 block resumes", {1'b0, pins}, 8'h73);
    func = 7'h5F; cyc(1);
    check("R8 release unblocks", {1'b0, pins}, 8'h5F);
    func = 7'h5B; cyc(10);
    func = 7'h5F; cyc(1);
    func = 7'h5B; cyc(10);
    check("R8 early release restarts", {1'b0, pins}, 8'h5B);
    func = 7'h5F; cyc(2);
  endtask

  task automatic t_tick();
    tick = 0;
    func = 7'h5B; cyc(50);
    check("R11 no tick no block", {1'b0, pins}, 8'h5B);
    tick = 1; cyc(30);
    check("R11 ticks resume block", {1'b0, pins}, 8'h73);
    func = 7'h5F; cyc(2);
  endtask

  task automatic t_invert_in();
    wr_pol(8'h80);
    func = 7'h5B; cyc(3);
    check("R10 inverted idle", {1'b0, pins}, 8'h5B);
    func = 7'h5F; cyc(30);
    check("R10 raw rise blocks", {1'b0, pins}, 8'h77);
    func = 7'h5B; cyc(2);
    wr_pol(8'h00); wr_ab(1'b0, 16'd0, 3'b000, 3'b000);
  endtask

  task automatic t_lock();
    func = 7'h00;
    pol_wd = 8'h01; pol_we = 1; wen_clr = 1; cyc(1);
    pol_we = 0; wen_clr = 0; cyc(1);
    check("R6 write with lock lands", {1'b0, pins}, 8'h01);
    check("R6 wen cleared", {7'b0, cfg_wen}, 8'h00);
    wr_pol(8'h00);
    check("R6 polarity locked", {1'b0, pins}, 8'h01);
    wr_allow(14'h0000);
    wr_ova(7'h10); wr_oen(7'h10);
    check("R6 allow locked, override live", {1'b0, pins}, 8'h11);
    wr_ab(1'b1, 16'd0, 3'b111, 3'b111);
    wr_oen(7'h00);
    func = 7'h04; cyc(2); func = 7'h00; cyc(5);
    check("R6 auto-block locked", {1'b0, pins}, 8'h01);
    do_reset();
    check("R6 reset unlocks", {7'b0, cfg_wen}, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    t_reset();
    t_pass();
    t_override();
    t_autoblock();
    t_tick();
    t_invert_in();
    t_lock();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule